// File: doc/BRIEF.md
# Stepped Feedback-Divider Selector

This block decides which of four stored fractional feedback-divider words a PLL should use, then walks the divider value it hands to the PLL toward that word in bounded steps, so the loop never sees a jump. The 2-bit choice comes from a fixed priority decode. First an enable bit is checked. Then come the function fields of two output-enable pins, which can act as one or two selection pins. A strap sampled once after power-up then picks whether two serial-bus pins or a register field supply the choice when neither enable pin is in selection mode.

The pin levels arrive from the board. They cross a synchronizer and must hold a new value for a programmable number of cycles before the block accepts it. The ramp moves by at most a programmable step once every programmable number of cycles, and it clamps the last move so that it ends exactly on the target. A combination that sets the second pin to selection mode while the first pin is not in that mode is reported as an error, and the previous choice is kept.

Top module: `freq_select_ramp`

## Requirements
- R1: With `fn_enable` low the candidate select is 00 and `combo_err` is low, whatever the mode fields and pin levels are.
- R2: With `fn_enable` high, `pin_a_mode` = 2'b11 and `pin_b_mode` not 2'b11, the candidate select is {0, `pin_a_lvl`}.
- R3: With `fn_enable` high and both mode fields 2'b11, the candidate select is {`pin_b_lvl`, `pin_a_lvl`}.
- R4: With `fn_enable` high, `pin_a_mode` other than 2'b11 and `pin_b_mode` = 2'b11, `combo_err` is high in that same cycle (it is combinational on the mode inputs) and the candidate equals the current `sel_idx`, so the select does not change.
- R5: With `fn_enable` high and neither mode field 2'b11, a captured strap of 0 gives the candidate {`bus_hi_lvl`, `bus_lo_lvl`}, and a captured strap of 1 gives the candidate `reg_sel`.
- R6: `strap_in` is captured at the first rising clock edge after reset is released, and later changes of `strap_in` have no effect until the next reset.
- R7: The applied divider moves monotonically toward the word of the current `sel_idx`, without passing it, and ends exactly on it. The default words are 0x100000, 0x100040, 0x100123 and 0x0FFFC0 for selects 00, 01, 10 and 11.
- R8: Each change of `div_applied` is at most max(`step_size`,1), and changes are at least max(`dwell_cycles`,1) clock edges apart.
- R9: The four pin levels pass through two synchronizer flops. A new candidate becomes `sel_idx` at the max(`settle_cycles`,1)-th edge after the edge at which the block first sees it, provided it stays unchanged throughout. A shorter pulse leaves `sel_idx` unchanged.
- R10: A change of `sel_idx` during a ramp redirects the ramp from the current applied value toward the new word.
- R11: `ramping` is high exactly when `div_applied` differs from the word of `sel_idx`.
- R12: After reset `sel_idx` is 00, `div_applied` is the select-00 word and `ramping` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_in | input | 1 | Strap level, captured once after reset |
| fn_enable | input | 1 | Enables the selection function |
| pin_a_mode | input | 2 | Function field of the first enable pin (11 = selection) |
| pin_b_mode | input | 2 | Function field of the second enable pin (11 = selection) |
| pin_a_lvl | input | 1 | Level of the first enable pin |
| pin_b_lvl | input | 1 | Level of the second enable pin |
| bus_hi_lvl | input | 1 | Level of the serial clock pin (select bit 1) |
| bus_lo_lvl | input | 1 | Level of the serial data pin (select bit 0) |
| reg_sel | input | 2 | Register-supplied select |
| step_size | input | DIV_W | Largest divider change per update |
| dwell_cycles | input | CNT_W | Clock edges between divider updates |
| settle_cycles | input | CNT_W | Edges a new candidate must hold |
| sel_idx | output | 2 | Accepted select |
| div_applied | output | DIV_W | Divider value applied now |
| ramping | output | 1 | Applied value differs from target |
| combo_err | output | 1 | Unsupported mode combination |

## Verification
Each source of the select is tried in turn: disabled, one-pin, two-pin, bus pins under a low strap, and the register under a high strap. Each setting drives levels that give a different index, so a swapped bit or a wrong priority shows up as a wrong select. Ramps are run both up and down, and one is redirected part-way. With step and dwell at zero, the clamping to one is exercised, and this separates stride errors from overshoot errors. A one-cycle pin glitch, a late change of the strap and the unsupported mode combination check that the select holds.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int SEL_W = 2;
   localparam int N_SEL = 1 << SEL_W;
   localparam logic [1:0] FN_SELECT = 2'b11;

   // bit positions inside the synchronized level vector
   localparam int LV_PIN_A  = 0;
   localparam int LV_PIN_B  = 1;
   localparam int LV_BUS_HI = 2;
   localparam int LV_BUS_LO = 3;
   localparam int LV_N      = 4;

   typedef enum logic [2:0] {
      SRC_OFF,
      SRC_ONE_PIN,
      SRC_TWO_PIN,
      SRC_BUS,
      SRC_REG,
      SRC_BAD
   } sel_src_e;
endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fsr_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("fsr_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/fsr_decode.sv
module fsr_decode
   import fsr_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strap_in,
   input  logic               fn_enable,
   input  logic [1:0]         pin_a_mode,
   input  logic [1:0]         pin_b_mode,
   input  logic [LV_N-1:0]    lv_sync,
   input  logic [SEL_W-1:0]   reg_sel,
   input  logic [SEL_W-1:0]   cur_sel,
   output logic [SEL_W-1:0]   cand,
   output logic               err,
   output sel_src_e           src
);
   logic strap_q;
   logic strap_done_q;

   // strap is sampled at the first edge after reset and frozen
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strap_q      <= 1'b0;
         strap_done_q <= 1'b0;
      end else if (!strap_done_q) begin
         strap_q      <= strap_in;
         strap_done_q <= 1'b1;
      end
   end

   // priority: enable, first pin, second pin alone (illegal), strap
   always_comb begin
      if (!fn_enable)                   src = SRC_OFF;
      else if (pin_a_mode == FN_SELECT) src = (pin_b_mode == FN_SELECT) ? SRC_TWO_PIN : SRC_ONE_PIN;
      else if (pin_b_mode == FN_SELECT) src = SRC_BAD;
      else                              src = strap_q ? SRC_REG : SRC_BUS;
   end

   always_comb begin
      err  = 1'b0;
      cand = '0;
      unique case (src)
         SRC_OFF:     cand = '0;
         SRC_ONE_PIN: cand = {1'b0, lv_sync[LV_PIN_A]};
         SRC_TWO_PIN: cand = {lv_sync[LV_PIN_B], lv_sync[LV_PIN_A]};
         SRC_BUS:     cand = {lv_sync[LV_BUS_HI], lv_sync[LV_BUS_LO]};
         SRC_REG:     cand = reg_sel;
         SRC_BAD: begin
            cand = cur_sel;
            err  = 1'b1;
         end
         default:     cand = '0;
      endcase
   end

   // R6: the captured strap never moves once taken
   p_strap_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      strap_done_q |=> $stable(strap_q));
endmodule

// File: rtl/fsr_settle.sv
module fsr_settle
   import fsr_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEL_W-1:0]   cand,
   input  logic [CNT_W-1:0]   settle_cycles,
   output logic [SEL_W-1:0]   sel
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("fsr_settle: CNT_W must be at least 1");
      end
   endgenerate

   logic [SEL_W-1:0] pend_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   need;
   logic [CNT_W:0]   cnt_nx;

   assign need   = (settle_cycles == '0) ? (CNT_W+1)'(1) : {1'b0, settle_cycles};
   assign cnt_nx = {1'b0, cnt_q} + (CNT_W+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         sel_q  <= '0;
         cnt_q  <= '0;
      end else if (cand != pend_q) begin
         pend_q <= cand;
         cnt_q  <= '0;
      end else if (pend_q != sel_q) begin
         if (cnt_nx >= need) begin
            sel_q <= pend_q;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_nx[CNT_W-1:0];
         end
      end else begin
         cnt_q <= '0;
      end
   end

   assign sel = sel_q;

   // R9: an accepted select is always the value that was pending
   p_accept_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q != $past(sel_q)) |-> (sel_q == $past(pend_q)));
endmodule

// File: rtl/fsr_ramp.sv
module fsr_ramp
   import fsr_pkg::*;
#(
   parameter int                     DIV_W   = 24,
   parameter int                     CNT_W   = 8,
   parameter logic [N_SEL*DIV_W-1:0] DIV_SET = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEL_W-1:0]   sel,
   input  logic [DIV_W-1:0]   step_size,
   input  logic [CNT_W-1:0]   dwell_cycles,
   output logic [DIV_W-1:0]   applied,
   output logic               ramping
);
   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("fsr_ramp: DIV_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("fsr_ramp: CNT_W must be at least 1");
      end
   endgenerate

   localparam logic [DIV_W-1:0] RESET_WORD = DIV_SET[DIV_W-1:0];

   logic [DIV_W-1:0] words [N_SEL];
   generate
      for (genvar i = 0; i < N_SEL; i++) begin : g_word
         assign words[i] = DIV_SET[i*DIV_W +: DIV_W];
      end
   endgenerate

   logic [DIV_W-1:0] target;
   logic [DIV_W-1:0] app_q;
   logic [DIV_W-1:0] gap;
   logic [DIV_W-1:0] mv;
   logic [DIV_W-1:0] step_eff;
   logic             go_up;
   logic [CNT_W-1:0] dcnt_q;
   logic [CNT_W:0]   dwell_eff;
   logic [CNT_W:0]   dcnt_nx;

   assign target    = words[sel];
   assign go_up     = target > app_q;
   assign gap       = go_up ? (target - app_q) : (app_q - target);
   assign step_eff  = (step_size == '0) ? DIV_W'(1) : step_size;
   assign mv        = (gap < step_eff) ? gap : step_eff;
   assign dwell_eff = (dwell_cycles == '0) ? (CNT_W+1)'(1) : {1'b0, dwell_cycles};
   assign dcnt_nx   = {1'b0, dcnt_q} + (CNT_W+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         app_q  <= RESET_WORD;
         dcnt_q <= '0;
      end else if (app_q != target) begin
         if (dcnt_nx >= dwell_eff) begin
            app_q  <= go_up ? (app_q + mv) : (app_q - mv);
            dcnt_q <= '0;
         end else begin
            dcnt_q <= dcnt_nx[CNT_W-1:0];
         end
      end else begin
         dcnt_q <= '0;
      end
   end

   assign applied = app_q;
   assign ramping = (app_q != target);

   // R7: an upward move never passes the target it was heading for
   p_no_overshoot_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (app_q < target) |=> (app_q >= $past(app_q)) && (app_q <= $past(target)));

   // R7: a downward move never passes the target it was heading for
   p_no_undershoot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (app_q > target) |=> (app_q <= $past(app_q)) && (app_q >= $past(target)));

   // R8: each change is bounded by the effective step
   p_step_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (app_q != $past(app_q)) |->
         (((app_q > $past(app_q)) ? (app_q - $past(app_q)) : ($past(app_q) - app_q))
            <= $past(step_eff)));
endmodule

// File: rtl/freq_select_ramp.sv
module freq_select_ramp
   import fsr_pkg::*;
#(
   parameter int                     DIV_W       = 24,
   parameter int                     CNT_W       = 8,
   parameter int                     SYNC_STAGES = 2,
   parameter logic [N_SEL*DIV_W-1:0] DIV_SET     = {24'h0FFFC0, 24'h100123, 24'h100040, 24'h100000}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap_in,
   input  logic             fn_enable,
   input  logic [1:0]       pin_a_mode,
   input  logic [1:0]       pin_b_mode,
   input  logic             pin_a_lvl,
   input  logic             pin_b_lvl,
   input  logic             bus_hi_lvl,
   input  logic             bus_lo_lvl,
   input  logic [1:0]       reg_sel,
   input  logic [DIV_W-1:0] step_size,
   input  logic [CNT_W-1:0] dwell_cycles,
   input  logic [CNT_W-1:0] settle_cycles,
   output logic [1:0]       sel_idx,
   output logic [DIV_W-1:0] div_applied,
   output logic             ramping,
   output logic             combo_err
);
   logic [LV_N-1:0]  lv_raw;
   logic [LV_N-1:0]  lv_sync;
   logic [SEL_W-1:0] cand;
   logic [SEL_W-1:0] sel;
   sel_src_e         src;

   assign lv_raw[LV_PIN_A]  = pin_a_lvl;
   assign lv_raw[LV_PIN_B]  = pin_b_lvl;
   assign lv_raw[LV_BUS_HI] = bus_hi_lvl;
   assign lv_raw[LV_BUS_LO] = bus_lo_lvl;

   fsr_sync #(.WIDTH(LV_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (lv_raw),
      .sync_out (lv_sync)
   );

   fsr_decode u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_in   (strap_in),
      .fn_enable  (fn_enable),
      .pin_a_mode (pin_a_mode),
      .pin_b_mode (pin_b_mode),
      .lv_sync    (lv_sync),
      .reg_sel    (reg_sel),
      .cur_sel    (sel),
      .cand       (cand),
      .err        (combo_err),
      .src        (src)
   );

   fsr_settle #(.CNT_W(CNT_W)) u_settle (
      .clk           (clk),
      .rst_n         (rst_n),
      .cand          (cand),
      .settle_cycles (settle_cycles),
      .sel           (sel)
   );

   fsr_ramp #(.DIV_W(DIV_W), .CNT_W(CNT_W), .DIV_SET(DIV_SET)) u_ramp (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel          (sel),
      .step_size    (step_size),
      .dwell_cycles (dwell_cycles),
      .applied      (div_applied),
      .ramping      (ramping)
   );

   assign sel_idx = sel;

   // R4: an unsupported combination keeps the select where it was
   p_err_holds_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (combo_err && (src == SRC_BAD)) |-> (cand == sel_idx));
endmodule

// File: tb/test_freq_select_ramp.sv
module test_freq_select_ramp;
   localparam int DW = 24;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strap_in = 1'b0;
   logic          fn_enable = 1'b0;
   logic [1:0]    pin_a_mode = 2'b00;
   logic [1:0]    pin_b_mode = 2'b00;
   logic          pin_a_lvl = 1'b0;
   logic          pin_b_lvl = 1'b0;
   logic          bus_hi_lvl = 1'b0;
   logic          bus_lo_lvl = 1'b0;
   logic [1:0]    reg_sel = 2'b00;
   logic [DW-1:0] step_size = 24'd16;
   logic [CW-1:0] dwell_cycles = 8'd2;
   logic [CW-1:0] settle_cycles = 8'd2;
   logic [1:0]    sel_idx;
   logic [DW-1:0] div_applied;
   logic          ramping;
   logic          combo_err;

   always #10 clk = ~clk;

   freq_select_ramp i_freq_select_ramp (
      .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .fn_enable(fn_enable),
      .pin_a_mode(pin_a_mode), .pin_b_mode(pin_b_mode),
      .pin_a_lvl(pin_a_lvl), .pin_b_lvl(pin_b_lvl),
      .bus_hi_lvl(bus_hi_lvl), .bus_lo_lvl(bus_lo_lvl), .reg_sel(reg_sel),
      .step_size(step_size), .dwell_cycles(dwell_cycles), .settle_cycles(settle_cycles),
      .sel_idx(sel_idx), .div_applied(div_applied), .ramping(ramping), .combo_err(combo_err)
   );

   int    vectors = 0;
   int    miscompares = 0;
   bit    chk_on = 1'b0;
   bit    finished = 1'b0;
   string phase = "R12";

   // behavioural reference state
   logic [3:0] m_s1, m_s2;     // two synchronizer samples: {bus_lo, bus_hi, pin_b, pin_a}
   bit         m_strap, m_strap_done;
   int         m_pend, m_sel, m_cnt, m_app, m_dcnt;

   function automatic int word_of(int i);
      case (i)
         0: return 32'h100000;
         1: return 32'h100040;
         2: return 32'h100123;
         default: return 32'h0FFFC0;
      endcase
   endfunction

   function automatic bit exp_err();
      return fn_enable && (pin_a_mode != 2'b11) && (pin_b_mode == 2'b11);
   endfunction

   function automatic int exp_cand();
      if (!fn_enable) return 0;
      if (pin_a_mode == 2'b11) begin
         if (pin_b_mode == 2'b11) return 2 * int'(m_s2[1]) + int'(m_s2[0]);
         return int'(m_s2[0]);
      end
      if (pin_b_mode == 2'b11) return m_sel;
      if (m_strap) return int'(reg_sel);
      return 2 * int'(m_s2[2]) + int'(m_s2[3]);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_strap = 0; m_strap_done = 0;
         m_pend = 0; m_sel = 0; m_cnt = 0; m_app = word_of(0); m_dcnt = 0;
      end else begin
         int c, tgt, need, dwell, stp, gap, n_sel, n_app;
         c     = exp_cand();
         tgt   = word_of(m_sel);
         need  = (settle_cycles == 0) ? 1 : int'(settle_cycles);
         dwell = (dwell_cycles == 0) ? 1 : int'(dwell_cycles);
         stp   = (step_size == 0) ? 1 : int'(step_size);
         n_sel = m_sel;
         n_app = m_app;
         if (m_app != tgt) begin
            if (m_dcnt + 1 >= dwell) begin
               gap   = (tgt > m_app) ? tgt - m_app : m_app - tgt;
               if (gap > stp) gap = stp;
               n_app = (tgt > m_app) ? m_app + gap : m_app - gap;
               m_dcnt = 0;
            end else m_dcnt++;
         end else m_dcnt = 0;
         if (c != m_pend) begin
            m_pend = c; m_cnt = 0;
         end else if (m_pend != m_sel) begin
            if (m_cnt + 1 >= need) begin n_sel = m_pend; m_cnt = 0; end
            else m_cnt++;
         end else m_cnt = 0;
         m_sel = n_sel;
         m_app = n_app;
         if (!m_strap_done) begin m_strap = strap_in; m_strap_done = 1; end
         m_s2 = m_s1;
         m_s1 = {bus_lo_lvl, bus_hi_lvl, pin_b_lvl, pin_a_lvl};
      end
   end

   always @(negedge clk) begin
      if (chk_on && !finished) begin
         bit bad;
         int e_ramp;
         bad = 0;
         e_ramp = (m_app != word_of(m_sel)) ? 1 : 0;
         if (int'(sel_idx) != m_sel) begin
            bad = 1;
            $display("FAIL %s/R9 sel_idx actual %0d expected %0d", phase, sel_idx, m_sel);
         end
         if (int'(div_applied) != m_app) begin
            bad = 1;
            $display("FAIL %s/R7 div_applied actual %h expected %h", phase, div_applied, m_app);
         end
         if (int'(ramping) != e_ramp) begin
            bad = 1;
            $display("FAIL %s/R11 ramping actual %0d expected %0d", phase, ramping, e_ramp);
         end
         if (combo_err != exp_err()) begin
            bad = 1;
            $display("FAIL %s/R4 combo_err actual %0d expected %0d", phase, combo_err, exp_err());
         end
         vectors++;
         if (bad) miscompares++;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   task automatic do_reset(input bit strap);
      chk_on = 0;
      cyc(1);
      rst_n = 0;
      strap_in = strap;
      cyc(3);
      rst_n = 1;
      phase = "R12";
      chk_on = 1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog expired (all requirements)");
      miscompares++;
      finish_run();
   end

   initial begin
      // R12 reset state with strap low, then R1 disabled with noisy pins
      do_reset(1'b0);
      cyc(3);
      phase = "R1";
      pin_a_mode = 2'b11; pin_b_mode = 2'b11; pin_a_lvl = 1; pin_b_lvl = 1;
      bus_hi_lvl = 1; bus_lo_lvl = 1;
      cyc(8);
      // R5 bus pins under a low strap: {hi,lo} = 10
      phase = "R5";
      pin_a_mode = 2'b00; pin_b_mode = 2'b00; bus_lo_lvl = 0;
      fn_enable = 1;
      cyc(6);
      phase = "R8";
      cyc(45);
      // R2 one-pin mode: {0, pin_a} = 01
      phase = "R2";
      pin_a_mode = 2'b11; pin_b_mode = 2'b01; pin_a_lvl = 1;
      cyc(40);
      // R9 one-cycle glitch on pin_a is filtered
      phase = "R9";
      pin_a_lvl = 0; cyc(1); pin_a_lvl = 1;
      cyc(10);
      // R3 two-pin mode, down ramp to 11, then R10 redirect to 01
      phase = "R3";
      pin_b_mode = 2'b11; pin_b_lvl = 1;
      cyc(12);
      phase = "R10";
      pin_b_lvl = 0;
      cyc(40);
      // R4 unsupported combination, then disabled with same fields (R1)
      phase = "R4";
      pin_a_mode = 2'b10; pin_b_mode = 2'b11;
      bus_hi_lvl = 1; bus_lo_lvl = 1;
      cyc(10);
      phase = "R1";
      fn_enable = 0;
      cyc(30);
      // R6 strap high selects the register; later strap changes ignored
      pin_a_mode = 2'b00; pin_b_mode = 2'b00;
      do_reset(1'b1);
      cyc(2);
      phase = "R6";
      strap_in = 0;
      fn_enable = 1; reg_sel = 2'b11;
      cyc(45);
      // R8 zero step and zero dwell clamp to one
      phase = "R8";
      step_size = '0; dwell_cycles = '0; settle_cycles = '0;
      reg_sel = 2'b00;
      cyc(80);
      phase = "R5";
      step_size = 24'd100; dwell_cycles = 8'd3;
      reg_sel = 2'b10;
      cyc(20);
      finish_run();
   end
endmodule